// File: doc/BRIEF.md
# CAN Error Event and Error Code Register Block

This block sits between a CAN protocol engine and a byte-wide CPU register bus. The engine reports each error condition as a one-cycle pulse. The block latches those pulses into two sets of sticky flags:

- **Error events:** bus lock, overload frame sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning and bus error.
- **Protocol error types:** stuff, form, ACK, CRC, recessive bit, dominant bit and ACK delimiter.

Software clears flags by writing a byte that holds a 0 in each bit position it wants to clear. An enable byte masks the event flags. Their masked OR forms one registered summary status bit. That bit drives the error interrupt line when its own enable is set.

The code store has two modes, chosen by bit 7 of its register. In accumulate mode, new protocol errors are ORed into the bits that are already set. In latest-error mode, a new protocol error replaces the whole field, so only the newest error is shown. The engine's transmit and receive error counts are registered and readable as two separate bytes.

The register map is:

| Offset | Register | Access |
|---|---|---|
| 0 | event flags | write 0 to clear |
| 1 | event enables | read/write |
| 2 | code store | bits 6..0 write 0 to clear, bit 7 mode |
| 3 | interrupt enable | bit 5 only |
| 4 | interrupt status | bit 5 only, read-only |
| 5 | transmit count | read-only |
| 6 | receive count | read-only |
| 7 | unused | reads 0 |

Top module: `can_err_report`

## Requirements
- R1: A pulse on `evt_pulse[i]` sets event flag i, and the flag stays set until it is cleared. The flag bits at offset 0, from bit 7 down to bit 0, are: bus lock, overload sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error.
- R2: A write to offset 0 clears each event flag whose written bit is 0 and leaves unchanged each flag whose written bit is 1. No other access ever clears an event flag.
- R3: If a flag's set pulse arrives in the same cycle as a write that clears it, the flag ends up set. This applies to both the event flags and the code bits.
- R4: The event enable register at offset 1 can be read and written, and its bit positions match the event flags.
- R5: Bit 5 of the interrupt status register (offset 4) is the registered OR of (event flags AND event enables), one cycle late. `irq_err` is registered in the same cycle and equals that OR gated by bit 5 of the interrupt enable register (offset 3). All other bits of offsets 3 and 4 read 0, and writes to offset 4 have no effect.
- R6: When code bit 7 (mode) is 1, each `code_pulse` bit is ORed into code bits 6..0. Code bit 0 is stuff error, 1 form error, 2 ACK error, 3 CRC error, 4 recessive bit error, 5 dominant bit error, and 6 ACK delimiter error.
- R7: When mode is 0, a cycle with any `code_pulse` bit set loads code bits 6..0 with exactly that pulse pattern. The mode value used is the one held before that cycle.
- R8: A write to offset 2 clears each code bit 6..0 whose written bit is 0, and loads bit 7 (mode) from the written byte.
- R9: The transmit and receive error counts are registered from their inputs and read at offsets 5 and 6.
- R10: Synchronous reset clears all flags, enables, the mode bit, the counts, `cpu_rdata` and `irq_err`.
- R11: `cpu_rdata` is registered: it shows the register at the address presented at the previous clock edge. Offset 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Write strobe for `cpu_addr` |
| cpu_addr | input | 3 | Register offset for both reads and writes |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| evt_pulse | input | 8 | Error event set pulses from the engine |
| code_pulse | input | 7 | Protocol error type set pulses from the engine |
| tx_err_cnt | input | 8 | Transmit error count from the engine |
| rx_err_cnt | input | 8 | Receive error count from the engine |
| irq_err | output | 1 | Registered error interrupt request |

## Verification
Two things can land on the same flag in the same cycle: an engine pulse that sets it, and a CPU write that clears it. The same is true for a code pulse and a write to the code register that changes the mode.

The random phase fires sparse pulses on every cycle while writing random bytes to offsets 0 and 2. Collisions therefore happen often, and a directed step forces one on purpose.

The bench model applies the clear and then the set, using the mode held before that edge. Each following read, and `irq_err` on every cycle, is compared against that model.

// File: rtl/can_err_report_pkg.sv
package can_err_report_pkg;
  localparam int EVT_W  = 8;
  localparam int CODE_W = 7;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int IRQ_BIT = 5;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd0;
  localparam logic [ADDR_W-1:0] A_FEN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CODE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_ISTS  = 3'd4;
  localparam logic [ADDR_W-1:0] A_TXC   = 3'd5;
  localparam logic [ADDR_W-1:0] A_RXC   = 3'd6;
endpackage

// File: rtl/cerr_flag_bank.sv
module cerr_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] keep_i,
  output logic [W-1:0] flags_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) flags_o[i] <= 1'b0;
      else if (set_i[i]) flags_o[i] <= 1'b1;
      else if (clr_we && !keep_i[i]) flags_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cerr_code_store.sv
module cerr_code_store #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W:0]   wdata_i,
  output logic [W-1:0] code_o,
  output logic         mode_o
);
  logic [W-1:0] keep;
  logic [W-1:0] code_d;

  always_comb begin
    keep = wr_i ? wdata_i[W-1:0] : '1;
    if (!mode_o && (|set_i)) code_d = set_i;
    else                     code_d = (code_o & keep) | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= '0;
      mode_o <= 1'b0;
    end else begin
      code_o <= code_d;
      if (wr_i) mode_o <= wdata_i[W];
    end
  end
endmodule

// File: rtl/cerr_irq_sum.sv
module cerr_irq_sum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] en_i,
  input  logic         ien_i,
  output logic         sts_o,
  output logic         irq_o
);
  logic hit;
  assign hit = |(flags_i & en_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      sts_o <= hit;
      irq_o <= hit & ien_i;
    end
  end
endmodule

// File: rtl/can_err_report.sv
module can_err_report
  import can_err_report_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [EVT_W-1:0]  evt_pulse,
  input  logic [CODE_W-1:0] code_pulse,
  input  logic [DATA_W-1:0] tx_err_cnt,
  input  logic [DATA_W-1:0] rx_err_cnt,
  output logic              irq_err
);
  logic [EVT_W-1:0]  flags_q;
  logic [EVT_W-1:0]  fen_q;
  logic [CODE_W-1:0] code_q;
  logic              mode_q;
  logic              ien_q;
  logic              sts_q;
  logic [DATA_W-1:0] txc_q;
  logic [DATA_W-1:0] rxc_q;
  logic [DATA_W-1:0] rd_d;
  logic              wr_flags;
  logic              wr_code;

  assign wr_flags = cpu_wr && (cpu_addr == A_FLAGS);
  assign wr_code  = cpu_wr && (cpu_addr == A_CODE);

  cerr_flag_bank #(.W(EVT_W)) u_flags (
    .clk(clk), .rst(rst), .set_i(evt_pulse), .clr_we(wr_flags),
    .keep_i(cpu_wdata[EVT_W-1:0]), .flags_o(flags_q)
  );

  cerr_code_store #(.W(CODE_W)) u_code (
    .clk(clk), .rst(rst), .set_i(code_pulse), .wr_i(wr_code),
    .wdata_i(cpu_wdata[CODE_W:0]), .code_o(code_q), .mode_o(mode_q)
  );

  cerr_irq_sum #(.W(EVT_W)) u_irq (
    .clk(clk), .rst(rst), .flags_i(flags_q), .en_i(fen_q), .ien_i(ien_q),
    .sts_o(sts_q), .irq_o(irq_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fen_q <= '0;
      ien_q <= 1'b0;
      txc_q <= '0;
      rxc_q <= '0;
    end else begin
      txc_q <= tx_err_cnt;
      rxc_q <= rx_err_cnt;
      if (cpu_wr && cpu_addr == A_FEN) fen_q <= cpu_wdata[EVT_W-1:0];
      if (cpu_wr && cpu_addr == A_IEN) ien_q <= cpu_wdata[IRQ_BIT];
    end
  end

  always_comb begin
    rd_d = '0;
    case (cpu_addr)
      A_FLAGS: rd_d[EVT_W-1:0] = flags_q;
      A_FEN:   rd_d[EVT_W-1:0] = fen_q;
      A_CODE:  rd_d[CODE_W:0]  = {mode_q, code_q};
      A_IEN:   rd_d[IRQ_BIT]   = ien_q;
      A_ISTS:  rd_d[IRQ_BIT]   = sts_q;
      A_TXC:   rd_d            = txc_q;
      A_RXC:   rd_d            = rxc_q;
      default: rd_d            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= rd_d;
  end
endmodule

// File: rtl/can_err_report_chk.sv
module can_err_report_chk
  import can_err_report_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [EVT_W-1:0]  evt_pulse,
  input logic [CODE_W-1:0] code_pulse,
  input logic [EVT_W-1:0]  flags_q,
  input logic [CODE_W-1:0] code_q,
  input logic              mode_q,
  input logic              sts_q,
  input logic              irq_err,
  input logic [DATA_W-1:0] cpu_rdata
);
  assert_pulse_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (|evt_pulse) |=> ((flags_q & $past(evt_pulse)) == $past(evt_pulse)));

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == A_FLAGS && (|evt_pulse))
      |=> ((flags_q & $past(evt_pulse)) == $past(evt_pulse)));

  assert_only_write_clears_R2: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wr && cpu_addr == A_FLAGS) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_accumulate_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !(cpu_wr && cpu_addr == A_CODE)) |=> ((code_q & $past(code_q)) == $past(code_q)));

  assert_latest_only_R7: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && (|code_pulse)) |=> (code_q == $past(code_pulse)));

  assert_irq_needs_status_R5: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> sts_q);

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (cpu_rdata == '0 && !irq_err && flags_q == '0 && !mode_q));
endmodule

bind can_err_report can_err_report_chk chk_i (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .evt_pulse(evt_pulse), .code_pulse(code_pulse), .flags_q(flags_q),
  .code_q(code_q), .mode_q(mode_q), .sts_q(sts_q), .irq_err(irq_err),
  .cpu_rdata(cpu_rdata)
);

// File: tb/can_err_report_tb_top.sv
module can_err_report_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       d_wr = 1'b0;
  logic [2:0] d_addr = '0;
  logic [7:0] d_wd = '0;
  logic [7:0] d_evt = '0;
  logic [6:0] d_code = '0;
  logic [7:0] d_tx = '0;
  logic [7:0] d_rx = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state
  logic [7:0] m_flags, m_fen, m_txc, m_rxc, m_rd;
  logic [6:0] m_code;
  logic       m_mode, m_ien, m_sts, m_irq;
  logic [2:0] m_raddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_err_report dut_i (
    .clk(clk), .rst(rst), .cpu_wr(d_wr), .cpu_addr(d_addr), .cpu_wdata(d_wd),
    .cpu_rdata(rdata), .evt_pulse(d_evt), .code_pulse(d_code),
    .tx_err_cnt(d_tx), .rx_err_cnt(d_rx), .irq_err(irq)
  );

  function automatic logic [7:0] f_read(input logic [2:0] a);
    case (a)
      3'd0: f_read = m_flags;
      3'd1: f_read = m_fen;
      3'd2: f_read = {m_mode, m_code};
      3'd3: f_read = {2'b0, m_ien, 5'b0};
      3'd4: f_read = {2'b0, m_sts, 5'b0};
      3'd5: f_read = m_txc;
      3'd6: f_read = m_rxc;
      default: f_read = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] f_flags(input logic [7:0] q, input logic [7:0] p,
                                         input logic clr, input logic [7:0] wd);
    f_flags = (clr ? (q & wd) : q) | p;
  endfunction

  function automatic logic [6:0] f_code(input logic [6:0] q, input logic mode,
                                        input logic [6:0] p, input logic clr,
                                        input logic [6:0] wd);
    if (!mode && (|p)) f_code = p;
    else               f_code = (clr ? (q & wd) : q) | p;
  endfunction

  task automatic model_step();
    logic hit;
    if (rst) begin
      m_flags = 0; m_fen = 0; m_txc = 0; m_rxc = 0; m_rd = 0;
      m_code = 0; m_mode = 0; m_ien = 0; m_sts = 0; m_irq = 0;
    end else begin
      hit = |(m_flags & m_fen);
      m_rd = f_read(d_addr);
      m_sts = hit;
      m_irq = hit & m_ien;
      m_flags = f_flags(m_flags, d_evt, d_wr && d_addr == 3'd0, d_wd);
      m_code = f_code(m_code, m_mode, d_code, d_wr && d_addr == 3'd2, d_wd[6:0]);
      if (d_wr && d_addr == 3'd2) m_mode = d_wd[7];
      if (d_wr && d_addr == 3'd1) m_fen = d_wd;
      if (d_wr && d_addr == 3'd3) m_ien = d_wd[5];
      m_txc = d_tx;
      m_rxc = d_rx;
    end
    m_raddr = d_addr;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic string f_tag(input logic [2:0] a);
    case (a)
      3'd0: f_tag = "R1/R2 flags read";
      3'd1: f_tag = "R4 enable read";
      3'd2: f_tag = "R6/R7/R8 code read";
      3'd3: f_tag = "R5 int enable read";
      3'd4: f_tag = "R5 int status read";
      3'd5: f_tag = "R9 tx count read";
      3'd6: f_tag = "R9 rx count read";
      default: f_tag = "R11 unused offset read";
    endcase
  endfunction

  task automatic tick(input string tag = "");
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag == "" ? f_tag(m_raddr) : tag, rdata, m_rd);
    check("R5 irq_err", {7'b0, irq}, {7'b0, m_irq});
  endtask

  task automatic idle();
    d_wr = 0; d_evt = 0; d_code = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    d_wr = 1; d_addr = a; d_wd = v;
    tick();
    d_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    d_addr = a;
    tick();
    tick(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    @(negedge clk);
    tick("R10 reset");
    tick("R10 reset");
    rst = 0;
    for (int a = 0; a < 8; a++) rd(3'(a), "R10 reset value");

    // R1: set two flags
    d_evt = 8'h81; tick(); idle();
    rd(3'd0, "R1 flags set");
    // R2: clear bit 0 only
    wr(3'd0, 8'hFE);
    rd(3'd0, "R2 write-zero clear");
    // R3: set pulse collides with full clear
    d_evt = 8'h80; d_wr = 1; d_addr = 3'd0; d_wd = 8'h00; tick(); idle();
    rd(3'd0, "R3 set beats clear");
    // R4/R5: enable and interrupt
    wr(3'd1, 8'h80);
    wr(3'd3, 8'h20);
    rd(3'd4, "R5 status set");
    rd(3'd1, "R4 enable readback");
    // R5: writes to status are ignored
    wr(3'd4, 8'h00);
    rd(3'd4, "R5 status write ignored");
    // R6: accumulate mode
    wr(3'd2, 8'h80);
    d_code = 7'h01; tick(); idle();
    d_code = 7'h08; tick(); idle();
    rd(3'd2, "R6 accumulate");
    // R8: clear one code bit, keep mode
    wr(3'd2, 8'hF7);
    rd(3'd2, "R8 code clear");
    // R7: latest-only mode
    wr(3'd2, 8'h7F);
    d_code = 7'h04; tick(); idle();
    rd(3'd2, "R7 latest only");
    // R3 on code bits
    d_code = 7'h10; d_wr = 1; d_addr = 3'd2; d_wd = 8'h00; tick(); idle();
    rd(3'd2, "R3 code set beats clear");
    // R9: counters
    d_tx = 8'hA5; d_rx = 8'h3C;
    rd(3'd5, "R9 tx count");
    rd(3'd6, "R9 rx count");
    rd(3'd7, "R11 unused offset");

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      d_evt  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      d_code = 7'($urandom) & 7'($urandom) & 7'($urandom);
      d_tx   = 8'($urandom);
      d_rx   = 8'($urandom);
      d_addr = 3'($urandom);
      d_wr   = (r[3:0] < 4'd5);
      d_wd   = 8'($urandom);
      if (r[7:4] == 4'd0) begin
        d_wr = 1;
        d_addr = 3'd0;
      end
      if (r[11:8] == 4'd0) begin
        d_wr = 1;
        d_addr = 3'd2;
      end
      tick();
    end
    idle();
    tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule